// File: doc/BRIEF.md
# Merging Store Buffer with Load Forwarding

This block sits between the commit point of a core and one write port of a data cache. Retired stores are pushed in with a byte address, a 64-bit data word and a byte-lane mask. The buffer keeps them until the cache port grants a write. Each entry covers one aligned doubleword (eight bytes). A store to a doubleword that already has a pending entry is folded into that entry instead of taking a new slot.

Loads probe the buffer before going to the cache. The probe compares the doubleword address of the load against every pending entry. It resolves in the same cycle, from the contents held at the start of that cycle. If the matching entry holds every byte the load asks for, the load takes its data from the buffer and does not need the cache. If only some of the requested bytes are held, a partial flag tells the core to wait for the drain.

Entries leave oldest first, at most one per cycle, and only in a cycle where the grant is high. When all slots are occupied, a store that cannot merge is turned away.

Top module: `store_merge_buffer`

## Requirements
- R1: Out of reset the buffer is empty: `dr_valid` is low, `full` is low, and loads report neither hit nor partial.
- R2: A store whose doubleword (address bits above bit 2) matches no pending entry takes a new slot. The slot records the data bytes enabled by the mask, with the disabled lanes zero. When the slot reaches the head, it is presented on `dr_addr` (low three bits zero), `dr_data` and `dr_mask`.
- R3: Entries leave in arrival order. In a cycle with `dr_grant` high and `dr_valid` high, the head entry is removed. With `dr_grant` low, nothing is removed and the head stays on the drain outputs.
- R4: A store that matches a pending entry which is not leaving in that cycle is merged into it. Its enabled bytes replace the stored bytes, the masks are ORed together, and the entry count does not change.
- R5: A store that matches only the head entry, in a cycle where that head is granted, does not merge. It takes a new slot at the tail instead.
- R6: Capacity is `DEPTH` entries (default 4), and `full` is high exactly when all of them are occupied. While full, a store that cannot merge is refused, even if the head drains in that cycle, and its data never appears at the drain.
- R7: While full, a store that matches a pending entry that is not leaving is still merged.
- R8: A valid load with a nonzero mask whose doubleword matches a pending entry holding every requested byte raises `ld_hit`. In that case `ld_data` carries the entry's bytes in the requested lanes and zero elsewhere.
- R9: A valid load with a nonzero mask whose matching entry lacks any requested byte raises `ld_partial`, keeps `ld_hit` low, and returns zero data.
- R10: A load with no matching entry, an all-zero mask or `ld_valid` low raises neither flag and returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store push strobe |
| st_addr | input | AW | Store byte address |
| st_data | input | 64 | Store data, lane i in bits 8i+7:8i |
| st_mask | input | 8 | Store byte-lane enables |
| ld_valid | input | 1 | Load probe strobe |
| ld_addr | input | AW | Load byte address |
| ld_mask | input | 8 | Load byte-lane request |
| ld_data | output | 64 | Forwarded bytes, zero unless hit |
| ld_hit | output | 1 | Load fully served by the buffer |
| ld_partial | output | 1 | Load overlaps a pending entry without full coverage |
| dr_valid | output | 1 | Head entry presented to the cache port |
| dr_addr | output | AW | Head doubleword address, low three bits zero |
| dr_data | output | 64 | Head data |
| dr_mask | output | 8 | Head byte-lane enables |
| dr_grant | input | 1 | Cache port accepts the head this cycle |
| full | output | 1 | All slots occupied |

## Verification
The assertions assume that every input is at a known level from the first edge after reset. They also allow `dr_grant` to be high while the buffer is empty, in which case it is ignored. They assume that each pending doubleword occupies at most one slot. This holds because a merge is always preferred, and a duplicate slot is created only in the cycle where the older copy leaves. The stimulus keeps store and load addresses within a handful of neighbouring doublewords, so merges, drains in the same cycle as a match, and full-buffer refusals occur often. Every input is driven on the falling edge and held until the next one.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int unsigned SB_LANES = 8;
  localparam int unsigned SB_DW    = 8 * SB_LANES;
  localparam int unsigned SB_OFS   = $clog2(SB_LANES);

  typedef logic [SB_DW-1:0]    sb_data_t;
  typedef logic [SB_LANES-1:0] sb_mask_t;

  // widen a lane mask to one bit per data bit
  function automatic sb_data_t sb_lane_fill(sb_mask_t m);
    sb_data_t f;
    for (int l = 0; l < SB_LANES; l++) f[8*l +: 8] = {8{m[l]}};
    return f;
  endfunction

  // overlay the enabled lanes of a new word onto an old word
  function automatic sb_data_t sb_overlay(sb_data_t old_d, sb_data_t new_d, sb_mask_t new_m);
    sb_data_t f;
    f = sb_lane_fill(new_m);
    return (old_d & ~f) | (new_d & f);
  endfunction

  // every requested lane is present
  function automatic logic sb_covers(sb_mask_t have, sb_mask_t want);
    return (want & ~have) == '0;
  endfunction
endpackage

// File: rtl/sbuf_match.sv
// Associative search over occupied slots; when more than one slot
// matches, the one furthest from the head (youngest) wins.
module sbuf_match #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TW    = 29,
  parameter int unsigned IW    = 2
) (
  input  logic             en,
  input  logic [DEPTH-1:0] occ,
  input  logic [TW-1:0]    tags [DEPTH],
  input  logic [IW-1:0]    head,
  input  logic [TW-1:0]    key,
  output logic             hit,
  output logic [IW-1:0]    idx
);
  logic [IW-1:0] slot_at [DEPTH];

  always_comb begin
    for (int a = 0; a < DEPTH; a++) slot_at[a] = head + IW'(a);
  end

  always_comb begin
    hit = 1'b0;
    idx = head;
    for (int a = 0; a < DEPTH; a++) begin
      if (en && occ[slot_at[a]] && tags[slot_at[a]] == key) begin
        hit = 1'b1;
        idx = slot_at[a];
      end
    end
  end
endmodule

// File: rtl/sbuf_fwd.sv
// Decides full, partial or no forwarding for a load probe.
module sbuf_fwd
  import sbuf_pkg::*;
(
  input  logic     match,
  input  sb_data_t ent_data,
  input  sb_mask_t ent_mask,
  input  sb_mask_t want,
  output logic     fwd_hit,
  output logic     fwd_partial,
  output sb_data_t fwd_data
);
  logic asks_any;
  logic covered;

  assign asks_any    = want != '0;
  assign covered     = sb_covers(ent_mask, want);
  assign fwd_hit     = match && asks_any && covered;
  assign fwd_partial = match && asks_any && !covered;
  assign fwd_data    = fwd_hit ? (ent_data & sb_lane_fill(want)) : '0;
endmodule

// File: rtl/store_merge_buffer.sv
module store_merge_buffer
  import sbuf_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                st_valid,
  input  logic [AW-1:0]       st_addr,
  input  logic [SB_DW-1:0]    st_data,
  input  logic [SB_LANES-1:0] st_mask,
  input  logic                ld_valid,
  input  logic [AW-1:0]       ld_addr,
  input  logic [SB_LANES-1:0] ld_mask,
  output logic [SB_DW-1:0]    ld_data,
  output logic                ld_hit,
  output logic                ld_partial,
  output logic                dr_valid,
  output logic [AW-1:0]       dr_addr,
  output logic [SB_DW-1:0]    dr_data,
  output logic [SB_LANES-1:0] dr_mask,
  input  logic                dr_grant,
  output logic                full
);
  localparam int unsigned TW = AW - SB_OFS;
  localparam int unsigned IW = $clog2(DEPTH);
  localparam int unsigned CW = IW + 1;

  logic [TW-1:0] tag_q  [DEPTH];
  sb_data_t      data_q [DEPTH];
  sb_mask_t      mask_q [DEPTH];
  logic [IW-1:0] head_q;
  logic [CW-1:0] count_q;

  logic [IW-1:0]    age  [DEPTH];
  logic [DEPTH-1:0] occ;
  logic [IW-1:0]    tail;

  // named events
  logic          pop;
  logic          s_hit, l_hit;
  logic [IW-1:0] s_idx, l_idx;
  logic          do_merge, do_alloc, st_refused;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      age[i] = IW'(i) - head_q;
      occ[i] = CW'(age[i]) < count_q;
    end
  end

  assign tail = head_q + count_q[IW-1:0];
  assign full = count_q == CW'(DEPTH);
  assign pop  = dr_grant && (count_q != '0);

  sbuf_match #(.DEPTH(DEPTH), .TW(TW), .IW(IW)) u_st_match (
    .en(st_valid), .occ(occ), .tags(tag_q), .head(head_q),
    .key(st_addr[AW-1:SB_OFS]), .hit(s_hit), .idx(s_idx)
  );

  sbuf_match #(.DEPTH(DEPTH), .TW(TW), .IW(IW)) u_ld_match (
    .en(ld_valid), .occ(occ), .tags(tag_q), .head(head_q),
    .key(ld_addr[AW-1:SB_OFS]), .hit(l_hit), .idx(l_idx)
  );

  // a leaving head cannot absorb a store
  assign do_merge   = st_valid && s_hit && !(pop && s_idx == head_q);
  assign do_alloc   = st_valid && !do_merge && !full;
  assign st_refused = st_valid && !do_merge && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
        mask_q[i] <= '0;
      end
    end else begin
      if (pop) head_q <= head_q + 1'b1;
      if (do_merge) begin
        data_q[s_idx] <= sb_overlay(data_q[s_idx], st_data, st_mask);
        mask_q[s_idx] <= mask_q[s_idx] | st_mask;
      end
      if (do_alloc) begin
        tag_q[tail]  <= st_addr[AW-1:SB_OFS];
        data_q[tail] <= sb_overlay('0, st_data, st_mask);
        mask_q[tail] <= st_mask;
      end
      count_q <= count_q + CW'(do_alloc) - CW'(pop);
    end
  end

  assign dr_valid = count_q != '0;
  assign dr_addr  = {tag_q[head_q], {SB_OFS{1'b0}}};
  assign dr_data  = data_q[head_q];
  assign dr_mask  = mask_q[head_q];

  sbuf_fwd u_fwd (
    .match(l_hit), .ent_data(data_q[l_idx]), .ent_mask(mask_q[l_idx]),
    .want(ld_mask), .fwd_hit(ld_hit), .fwd_partial(ld_partial), .fwd_data(ld_data)
  );

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  a_r6_refused_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    st_refused && !pop |=> full);

  a_r3_pop_advances_head: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (head_q - $past(head_q)) == IW'(1));

  a_r3_hold_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid && !dr_grant && !st_valid |=> dr_valid && $stable(dr_addr) && $stable(dr_mask));

  a_r4_merge_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    do_merge && !pop |=> count_q == $past(count_q));

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_partial));

  a_r10_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_hit |-> ld_data == '0);
endmodule

// File: tb/store_merge_buffer_bench.sv
module store_merge_buffer_bench;
  localparam int AW = 32;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [63:0] st_data = '0;
  logic [7:0]  st_mask = '0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_addr = '0;
  logic [7:0]  ld_mask = '0;
  logic        dr_grant = 1'b0;
  logic [63:0] ld_data, dr_data;
  logic        ld_hit, ld_partial, dr_valid, full;
  logic [31:0] dr_addr;
  logic [7:0]  dr_mask;

  always #5 clk = ~clk;

  store_merge_buffer #(.AW(AW), .DEPTH(DEPTH)) u_store_merge_buffer (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_mask(st_mask),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_mask(ld_mask),
    .ld_data(ld_data), .ld_hit(ld_hit), .ld_partial(ld_partial),
    .dr_valid(dr_valid), .dr_addr(dr_addr), .dr_data(dr_data), .dr_mask(dr_mask),
    .dr_grant(dr_grant), .full(full)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference list, index 0 = oldest
  logic [28:0] mt [DEPTH];
  logic [63:0] md [DEPTH];
  logic [7:0]  mm [DEPTH];
  int          mn = 0;

  function automatic logic [63:0] widen(logic [7:0] m);
    logic [63:0] r = '0;
    for (int b = 0; b < 8; b++) if (m[b]) r[8*b +: 8] = 8'hFF;
    return r;
  endfunction

  task automatic chk(string req, logic ok, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [28:0] t;
    logic        popm, was_full;
    int          j;
    t = st_addr[31:3];
    popm = dr_grant && mn > 0;
    was_full = mn == DEPTH;
    j = -1;
    if (st_valid)
      for (int k = 0; k < mn; k++) if (mt[k] == t && !(popm && k == 0)) j = k;
    if (popm) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        mt[k] = mt[k+1]; md[k] = md[k+1]; mm[k] = mm[k+1];
      end
      mn--;
      if (j >= 0) j--;
    end
    if (st_valid && j >= 0) begin
      md[j] = (md[j] & ~widen(st_mask)) | (st_data & widen(st_mask));
      mm[j] = mm[j] | st_mask;
    end else if (st_valid && !was_full) begin
      mt[mn] = t; md[mn] = st_data & widen(st_mask); mm[mn] = st_mask;
      mn++;
    end
  endtask

  task automatic compare_all();
    int k; logic eh, ep; logic [63:0] ed; string lr;
    chk("R6 full", full == (mn == DEPTH), 64'(full), 64'(mn == DEPTH));
    chk("R2 drain valid", dr_valid == (mn > 0), 64'(dr_valid), 64'(mn > 0));
    if (mn > 0) begin
      chk("R2 drain addr", dr_addr == {mt[0], 3'b000}, 64'(dr_addr), 64'({mt[0], 3'b000}));
      chk("R2 drain data", dr_data == md[0], dr_data, md[0]);
      chk("R2 drain mask", dr_mask == mm[0], 64'(dr_mask), 64'(mm[0]));
    end
    k = -1;
    if (ld_valid) for (int q = 0; q < mn; q++) if (mt[q] == ld_addr[31:3]) k = q;
    eh = k >= 0 && ld_mask != 0 && (ld_mask & ~mm[k]) == 0;
    ep = k >= 0 && ld_mask != 0 && !eh;
    ed = eh ? (md[k] & widen(ld_mask)) : 64'h0;
    lr = eh ? "R8 load" : (ep ? "R9 load" : "R10 load");
    chk({lr, " hit"}, ld_hit == eh, 64'(ld_hit), 64'(eh));
    chk({lr, " partial"}, ld_partial == ep, 64'(ld_partial), 64'(ep));
    chk({lr, " data"}, ld_data == ed, ld_data, ed);
  endtask

  // one cycle: drive on the falling edge, compare, then let the edge happen
  task automatic cyc(logic sv, logic [31:0] sa, logic [63:0] sd, logic [7:0] sm,
                     logic lv, logic [31:0] la, logic [7:0] lm, logic g);
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; st_mask = sm;
    ld_valid = lv; ld_addr = la; ld_mask = lm; dr_grant = g;
    #1;
    compare_all();
    @(posedge clk);
    model_step();
  endtask

  task automatic probe(logic [31:0] la, logic [7:0] lm);
    @(negedge clk);
    st_valid = 0; dr_grant = 0; ld_valid = 1; ld_addr = la; ld_mask = lm;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 empty", !dr_valid && !full && !ld_hit && !ld_partial,
        {60'h0, dr_valid, full, ld_hit, ld_partial}, 64'h0);

    // fill with four distinct doublewords
    cyc(1, 32'h100, 64'h1111_2222_3333_4444, 8'h0F, 0, 0, 0, 0);
    cyc(1, 32'h10C, 64'h5555_6666_7777_8888, 8'h0F, 0, 0, 0, 0);
    cyc(1, 32'h110, 64'h9999_AAAA_BBBB_CCCC, 8'h0F, 0, 0, 0, 0);
    cyc(1, 32'h118, 64'hDDDD_EEEE_FFFF_0000, 8'hFF, 0, 0, 0, 0);
    #1;
    chk("R6 full after four", full, 64'(full), 64'h1);
    chk("R2 head addr", dr_addr == 32'h100, 64'(dr_addr), 64'h100);
    chk("R2 head data", dr_data == 64'h0000_0000_3333_4444, dr_data, 64'h0000_0000_3333_4444);

    // merge while full into second entry (upper lanes)
    cyc(1, 32'h108, 64'hABCD_EF01_0000_0000, 8'hF0, 0, 0, 0, 0);
    probe(32'h108, 8'hFF);
    chk("R7 merged hit", ld_hit, 64'(ld_hit), 64'h1);
    chk("R4 merged data", ld_data == 64'hABCD_EF01_7777_8888, ld_data, 64'hABCD_EF01_7777_8888);
    chk("R6 still full", full, 64'(full), 64'h1);

    // refused while full, even with grant
    cyc(1, 32'h200, 64'hDEAD_BEEF_DEAD_BEEF, 8'hFF, 0, 0, 0, 1);
    probe(32'h200, 8'h01);
    chk("R6 refused store absent", !ld_hit && !ld_partial, 64'(ld_hit), 64'h0);
    chk("R3 one popped", !full && dr_addr == 32'h108, 64'(dr_addr), 64'h108);

    probe(32'h110, 8'hFF);
    chk("R9 partial", ld_partial && !ld_hit && ld_data == 0, 64'(ld_partial), 64'h1);
    probe(32'h300, 8'hFF);
    chk("R10 miss", !ld_partial && !ld_hit, 64'(ld_hit), 64'h0);
    probe(32'h118, 8'h00);
    chk("R10 zero mask", !ld_partial && !ld_hit, 64'(ld_hit), 64'h0);

    // store to the leaving head allocates a fresh slot
    cyc(1, 32'h108, 64'h0000_0000_0000_00EE, 8'h01, 0, 0, 0, 1);
    probe(32'h108, 8'h01);
    chk("R5 fresh slot", ld_hit && ld_data == 64'hEE, ld_data, 64'hEE);
    probe(32'h108, 8'h02);
    chk("R5 old bytes gone", ld_partial, 64'(ld_partial), 64'h1);

    // drain without grant holds
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R3 held without grant", dr_addr == 32'h110, 64'(dr_addr), 64'h110);
    // drain in order
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    #1;
    chk("R3 order second", dr_addr == 32'h118, 64'(dr_addr), 64'h118);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    #1;
    chk("R3 order third", dr_addr == 32'h108 && dr_mask == 8'h01, 64'(dr_addr), 64'h108);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);

    // lane sweep of load masks against one entry
    cyc(1, 32'h400, 64'h0102_0304_0506_0708, 8'h5A, 0, 0, 0, 0);
    for (int m = 0; m < 256; m++) cyc(0, 0, 0, 0, 1, 32'h404, 8'(m), 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);

    // mixed traffic over four neighbouring doublewords
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r = $urandom;
      cyc(r[0] | r[1], 32'h800 + {27'h0, r[3:2], 3'(r[6:4])}, {$urandom, $urandom}, r[15:8],
          r[16], 32'h800 + {27'h0, r[18:17], 3'b000}, r[26:19], r[27] & r[28]);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule